// File: doc/BRIEF.md
# Multislope Rundown Sequencer

This block sequences a capacitor-based time interval converter that resolves the residual charge through a series of progressively weaker zero-crossing phases. When a start request arrives while it is idle, it opens the shunt switch across the integrating capacitor and waits for the measured interval. While the interval input is high, it enables the strongest current source with positive polarity and counts reference clock cycles.

When the interval ends, the block runs a fixed number of phases. Each phase enables one current source, a quarter the strength of the source before it, with its polarity set to push the capacitor voltage back through zero. A phase ends on the first clock edge at which the synchronised comparator shows the capacitor on the far side of zero. Overshoot caused by the synchroniser delay is harmless, because every cycle a source is enabled is counted and weighted by that source's strength. The weighted, signed sum of all phase counts is the result, and a one-cycle done strobe marks it as ready. After the final phase, or after an aborted phase, the shunt switch closes again and stays closed until the next start.

A phase that sees no zero crossing within a programmable cycle limit aborts the sequence and raises a fault flag.

Top module: `rundown_seq`

## Requirements
- R1: After reset, `shunt_on` is 1, `src_en` is all zeros, and `done` and `fault` are 0.
- R2: A `start` accepted while idle opens the shunt (`shunt_on`=0) with no source enabled until `meas_active` is seen high. Then, while the runup lasts, only `src_en[0]` is set, with `src_pos`=1.
- R3: After the runup, phases k = 1 to NPH follow in order. Phase k enables only `src_en[k-1]` and sets `src_pos`=0 for odd k and `src_pos`=1 for even k. At no time is more than one `src_en` bit set.
- R4: `cmp_above`=1 means the capacitor is above zero. It passes through a two-flop synchroniser. A phase ends on the first edge at which the synchronised value equals `src_pos`, so the source stays enabled for exactly two cycles after the cycle in which `cmp_above` first reaches that value.
- R5: `result` is a two's-complement sum over the runup and all phases. Each term is the number of cycles the source was enabled, shifted left by 2*(NPH-1-j) bits, where j is the enabled `src_en` index. A term is added when `src_pos`=1 and subtracted when `src_pos`=0.
- R6: `done` pulses high for exactly one cycle, in the first cycle after the last phase ends. At that point `result` is final, and it holds until the next accepted start.
- R7: `shunt_on` is 1 whenever the block is idle, including after `done`, and is never 1 while any `src_en` bit is set.
- R8: A `start` that arrives while a measurement is in progress is ignored. The phase order, the result and the single `done` pulse are unchanged.
- R9: If a phase lasts `timeout_lim` cycles (nonzero) without its zero crossing, the sequence aborts after exactly that many enabled cycles. All sources turn off, the shunt closes, `fault` goes to 1 and stays there until the next accepted start, and no `done` is issued. A `timeout_lim` of 0 disables the check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Measurement request, accepted only when idle |
| meas_active | input | 1 | High during the interval being measured |
| cmp_above | input | 1 | Asynchronous comparator output, 1 when the capacitor is above zero |
| timeout_lim | input | TW | Per-phase cycle limit, 0 disables the limit |
| src_en | output | NPH | One-hot current source enables, bit j has strength 4^-j |
| src_pos | output | 1 | Current polarity, 1 charges positive |
| shunt_on | output | 1 | Capacitor shunt switch drive |
| result | output | CW+2*NPH+2 | Weighted signed phase-count sum |
| done | output | 1 | One-cycle strobe when the result is final |
| fault | output | 1 | Sticky abort flag after a phase timeout |

## Verification
The assertions assume that `cmp_above` is produced by a capacitor that integrates the enabled source and is cleared by the shunt. They also assume that `meas_active` stays high for several cycles once it rises, and that `timeout_lim` changes only while the block is idle. The bench keeps within these limits by deriving `cmp_above` from an integer charge model updated on every falling edge, and by changing the limit only between measurements. The model's final charge must equal `result`, which ties the weighting and the cycle counting together. For the timeout case, the bench pins the comparator high so that the first rundown never crosses zero.

// File: rtl/rdn_pkg.sv
package rdn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNUP,
        ST_PHASE
    } seq_state_e;

    // Source drive chosen by the sequencer for the current cycle
    typedef struct packed {
        logic       on;
        logic       pos;
        logic [7:0] src;
    } drive_t;

    // Left shift giving the relative strength of source j among nph sources
    function automatic int weight_shift(input int src, input int nph);
        return 2 * (nph - 1 - src);
    endfunction

endpackage

// File: rtl/rdn_sync.sv
module rdn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rdn_timer.sv
module rdn_timer #(
    parameter int CW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic [CW:0]   span,
    output logic          expired
);
    localparam int MW = (CW + 1 > TW) ? CW + 1 : TW;

    logic [MW-1:0] span_x, lim_x;

    assign span   = {1'b0, cnt} + 1'b1;
    assign span_x = MW'(span);
    assign lim_x  = MW'(lim);
    assign expired = run && (lim != '0) && (span_x >= lim_x);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rdn_accum.sv
module rdn_accum
    import rdn_pkg::*;
#(
    parameter int CW  = 16,
    parameter int RW  = 38,
    parameter int NPH = 10,
    parameter int IW  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add_en,
    input  logic          pos,
    input  logic [IW-1:0] src,
    input  logic [CW:0]   span,
    output logic [RW-1:0] acc
);
    logic [RW-1:0] mag;
    int            sh;

    always_comb begin
        sh  = weight_shift(int'(src), NPH);
        mag = RW'(span) << sh;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (add_en)  acc <= pos ? acc + mag : acc - mag;
    end

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !clear) |=> $stable(acc));
endmodule

// File: rtl/rundown_seq.sv
module rundown_seq
    import rdn_pkg::*;
#(
    parameter int  NPH  = 10,
    parameter int  CW   = 16,
    parameter int  TW   = 16,
    parameter int  SYNC = 2,
    localparam int RW   = CW + 2 * NPH + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           meas_active,
    input  logic           cmp_above,
    input  logic [TW-1:0]  timeout_lim,
    output logic [NPH-1:0] src_en,
    output logic           src_pos,
    output logic           shunt_on,
    output logic [RW-1:0]  result,
    output logic           done,
    output logic           fault
);
    localparam int PHW = $clog2(NPH + 1);
    localparam int IW  = (NPH > 1) ? $clog2(NPH) : 1;
    localparam int MW  = (CW > TW) ? CW : TW;

    seq_state_e     state;
    logic [PHW-1:0] ph;
    drive_t         drv;
    logic           cmp_s, hit, exit_runup, add_en, abort, expired, last;
    logic [CW-1:0]  cnt;
    logic [CW:0]    span;

    rdn_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst(rst), .d(cmp_above), .q(cmp_s)
    );

    always_comb begin
        drv = '0;
        case (state)
            ST_RUNUP: begin
                drv.on  = 1'b1;
                drv.pos = 1'b1;
            end
            ST_PHASE: begin
                drv.on  = 1'b1;
                drv.pos = ~ph[0];
                drv.src = 8'(ph) - 8'd1;
            end
            default: ;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NPH; i++) src_en[i] = drv.on && (drv.src == 8'(i));
    end

    assign src_pos    = drv.pos;
    assign shunt_on   = (state == ST_IDLE);
    assign hit        = (state == ST_PHASE) && (cmp_s == drv.pos);
    assign exit_runup = (state == ST_RUNUP) && !meas_active;
    assign add_en     = hit || exit_runup;
    assign abort      = (state == ST_PHASE) && !hit && expired;
    assign last       = (ph == PHW'(NPH));

    rdn_timer #(.CW(CW), .TW(TW)) u_timer (
        .clk(clk), .rst(rst), .clear(!drv.on || add_en), .run(drv.on),
        .lim(timeout_lim), .cnt(cnt), .span(span), .expired(expired)
    );

    rdn_accum #(.CW(CW), .RW(RW), .NPH(NPH), .IW(IW)) u_accum (
        .clk(clk), .rst(rst), .clear(shunt_on && start), .add_en(add_en),
        .pos(drv.pos), .src(drv.src[IW-1:0]), .span(span), .acc(result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ph    <= '0;
            done  <= 1'b0;
            fault <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_WAIT;
                    fault <= 1'b0;
                end
                ST_WAIT: if (meas_active) state <= ST_RUNUP;
                ST_RUNUP: if (!meas_active) begin
                    state <= ST_PHASE;
                    ph    <= PHW'(1);
                end
                ST_PHASE: begin
                    if (hit) begin
                        if (last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end else if (abort) begin
                        state <= ST_IDLE;
                        fault <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_en));
    // R7
    shunt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        shunt_on |-> (src_en == '0));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    done_shunt_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> shunt_on);
    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (src_en == '0));
    // R9
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PHASE) && (timeout_lim != '0)) |-> (MW'(cnt) < MW'(timeout_lim)));
endmodule

// File: tb/sim_rundown_seq.sv
`timescale 1ns/1ps
module sim_rundown_seq;
    localparam int NPH = 10;
    localparam int CW  = 16;
    localparam int TW  = 16;
    localparam int RW  = CW + 2 * NPH + 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           meas_active = 1'b0;
    logic           cmp_above = 1'b0;
    logic [TW-1:0]  timeout_lim = 16'd1000;
    logic [NPH-1:0] src_en;
    logic           src_pos;
    logic           shunt_on;
    logic [RW-1:0]  result;
    logic           done;
    logic           fault;

    int tests = 0;
    int fails = 0;

    // charge model state
    longint v = 0;
    longint v_done = 0;
    bit     force_on = 1'b0;
    bit     force_val = 1'b0;
    bit     chk_late = 1'b1;
    logic [NPH-1:0] cur_en = '0;
    logic   cur_pos = 1'b0;
    int     seq_n = 0;
    int     r3_bad = 0;
    int     r4_bad = 0;
    int     late = 0;
    bit     crossed = 1'b0;
    int     run_len = 0;
    int     last_len = 0;
    int     done_cnt = 0;

    always #2 clk = ~clk;

    rundown_seq #(.NPH(NPH), .CW(CW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .start(start), .meas_active(meas_active),
        .cmp_above(cmp_above), .timeout_lim(timeout_lim), .src_en(src_en),
        .src_pos(src_pos), .shunt_on(shunt_on), .result(result),
        .done(done), .fault(fault)
    );

    // Capacitor and comparator model, updated once per cycle on the falling edge
    always @(negedge clk) begin
        int j;
        int exp_idx;
        bit exp_pos;
        j = -1;
        for (int i = 0; i < NPH; i++) if (src_en[i]) j = i;
        if ((src_en != cur_en) || (src_en != '0 && src_pos != cur_pos)) begin
            if (cur_en != '0) begin
                last_len = run_len;
                if (seq_n > 1 && chk_late && late != 2) r4_bad++;
            end
            if (src_en != '0) begin
                exp_idx = (seq_n == 0) ? 0 : seq_n - 1;
                exp_pos = (seq_n == 0) ? 1'b1 : ((seq_n % 2) == 0);
                if (j != exp_idx || src_pos != exp_pos) r3_bad++;
                seq_n++;
            end
            cur_en  = src_en;
            cur_pos = src_pos;
            run_len = 0;
            crossed = 1'b0;
            late    = 0;
        end
        if (j >= 0) begin
            run_len++;
            if (crossed) late++;
            if (src_pos) v = v + (longint'(1) << (2 * (NPH - 1 - j)));
            else         v = v - (longint'(1) << (2 * (NPH - 1 - j)));
        end
        if (done) begin
            v_done = v;
            done_cnt++;
        end
        if (shunt_on) v = 0;
        cmp_above = force_on ? force_val : (v > 0);
        if (j >= 0 && seq_n > 1 && !crossed && cmp_above == src_pos) crossed = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk(shunt_on == 1'b1, "R1 shunt", shunt_on, 1);
        chk(src_en == '0, "R1 src_en", src_en, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(fault == 1'b0, "R1 fault", fault, 0);
    endtask

    task automatic t_measure(input int runup, input bit poke);
        bit got;
        longint res;
        seq_n = 0; r3_bad = 0; r4_bad = 0; done_cnt = 0; chk_late = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(posedge clk); #1;
        chk(shunt_on == 1'b0 && src_en == '0, "R2 waiting", {shunt_on, src_en}, 0);
        chk(fault == 1'b0, "R9 fault cleared", fault, 0);
        @(negedge clk); meas_active = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(src_en == 1 && src_pos == 1'b1, "R2 runup drive", {src_en, src_pos}, 3);
        repeat (runup) @(negedge clk);
        meas_active = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        got = 1'b0;
        for (int c = 0; c < 5000 && !got; c++) begin
            @(posedge clk); #1;
            if (done) got = 1'b1;
        end
        chk(got, "R6 done seen", got, 1);
        res = $signed(result);
        @(posedge clk); #1;
        chk(done == 1'b0, "R6 single pulse", done, 0);
        chk(res == v_done, "R5 weighted sum", res, v_done);
        chk(shunt_on == 1'b1, "R7 shunt after done", shunt_on, 1);
        chk(seq_n == NPH + 1, "R3 phase count", seq_n, NPH + 1);
        chk(r3_bad == 0, "R3 order and polarity", r3_bad, 0);
        chk(r4_bad == 0, "R4 two-cycle detect lag", r4_bad, 0);
        if (poke) chk(done_cnt == 1, "R8 start ignored", done_cnt, 1);
        repeat (10) @(posedge clk);
        #1;
        chk($signed(result) == res, "R6 result held", $signed(result), res);
        chk(shunt_on == 1'b1 && src_en == '0, "R7 shunt stays", {shunt_on, src_en}, 1 << NPH);
    endtask

    task automatic t_timeout();
        bit got;
        timeout_lim = 16'd20;
        force_on = 1'b1; force_val = 1'b1; chk_late = 1'b0;
        seq_n = 0; done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        meas_active = 1'b1;
        repeat (10) @(negedge clk);
        meas_active = 1'b0;
        got = 1'b0;
        for (int c = 0; c < 500 && !got; c++) begin
            @(posedge clk); #1;
            if (fault) got = 1'b1;
        end
        chk(got, "R9 fault raised", got, 1);
        @(posedge clk); #1;
        chk(src_en == '0 && shunt_on == 1'b1, "R9 aborted drive", {shunt_on, src_en}, 1 << NPH);
        chk(last_len == 20, "R9 phase length at abort", last_len, 20);
        repeat (5) @(posedge clk);
        #1;
        chk(fault == 1'b1, "R9 fault sticky", fault, 1);
        chk(done_cnt == 0, "R9 no done", done_cnt, 0);
        force_on = 1'b0;
        timeout_lim = 16'd1000;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_measure(40, 1'b0);
        t_measure(97, 1'b1);
        t_timeout();
        t_measure(150, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule